// File: doc/BRIEF.md
# Digit-Serial Packed BCD Adder

This unit adds two packed-BCD operands and an incoming carry flag one decimal digit per clock. A one-cycle `start` pulse captures both operands, the carry, the overflow flag and the width select. The unit then works from the least significant nibble upward. At each nibble it reduces the digit sum modulo ten and passes a carry of one to the next digit. It handles four digits in word mode and two digits in byte mode.

When the last digit has been processed, the unit loads the packed sum and the carry, negative, zero and overflow flags into output registers, and `done` pulses for one cycle. The outputs keep those values until the next operation completes. This lets the execution stage that issued the operation read them at any later time. Operand fetch, write-back and binary arithmetic belong to the surrounding core.

Top module: `bcd_serial_adder`

## Requirements
- R1: After reset, `busy`, `done`, `sumOut`, `carryOut`, `negOut`, `zeroOut` and `vOut` are all zero.
- R2: A `start` sampled while `busy` is low captures `opA`, `opB`, `carryIn`, `byteMode` and `vIn`. `busy` is high from the next cycle until the operation completes. Changes on those inputs during that time have no effect.
- R3: `done` is high for exactly one cycle. It rises 4 clock edges after the accepted `start` in word mode and 2 edges after it in byte mode. `busy` falls on the same edge.
- R4: The digit at nibble position 0 (bits 3:0) is the sum of both low nibbles plus `carryIn`. Each digit sum s yields the result digit s mod 10 and a carry of 1 into the next higher nibble when s >= 10, otherwise 0.
- R5: `carryOut` is 1 when the sum of the most significant processed digit is 10 or more, and 0 otherwise. In that case the digit itself is reduced modulo 10.
- R6: Word mode (`byteMode`=0) processes nibbles at bits 15:0. Byte mode (`byteMode`=1) processes bits 7:0 and forces `sumOut[15:8]` to zero.
- R7: `negOut` equals `sumOut[15]` in word mode and `sumOut[7]` in byte mode.
- R8: `zeroOut` is 1 exactly when `sumOut` is zero.
- R9: `vOut` returns the `vIn` value captured at the accepted start. The decimal add leaves overflow unchanged.
- R10: Nibbles holding A to F are added under the same modulo-10 rule with no error indication. For example, byte 0xFF + 0x01 with no carry-in gives 0x66 with carry 1.
- R11: A `start` sampled while `busy` is high is ignored. The running operation finishes on its original schedule with its original result.
- R12: `sumOut` and the four flags change only on the edge that raises `done`, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a decimal add; taken only when idle |
| byteMode | input | 1 | 1 = two-digit byte add, 0 = four-digit word add |
| opA | input | 16 | First packed-BCD operand |
| opB | input | 16 | Second packed-BCD operand |
| carryIn | input | 1 | Incoming carry flag, added into digit 0 |
| vIn | input | 1 | Current overflow flag, passed through unchanged |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| sumOut | output | 16 | Packed-BCD result |
| carryOut | output | 1 | Decimal carry out of the top processed digit |
| negOut | output | 1 | Sign bit of the result for the selected width |
| zeroOut | output | 1 | Result is zero |
| vOut | output | 1 | Overflow flag, unchanged by the add |

## Verification
The result and all flags belong to the edge that raises `done`. That edge is the fourth after the accepted start in word mode and the second in byte mode. `busy` drops on that same edge, so a start presented in the `done` cycle is accepted. The reference model in the bench keeps a countdown loaded on each accepted start. It applies its integer digit-by-digit result on the edge where the countdown expires. Every output is compared against the model half a period after each edge, so an early, late or repeated `done` shows up on the exact cycle it occurs. Directed cases wait for `done` and then compare hand-computed constants in that same cycle.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;
  localparam int DIGIT_W     = 4;
  localparam int NUM_DIGITS  = 4;
  localparam int BYTE_DIGITS = NUM_DIGITS / 2;
  localparam int DATA_W      = DIGIT_W * NUM_DIGITS;
  localparam int HALF_W      = DATA_W / 2;
  localparam int IDX_W       = $clog2(NUM_DIGITS);

  typedef struct packed {
    logic             load;
    logic             step;
    logic             finish;
    logic             byteSel;
    logic [IDX_W-1:0] idx;
  } bcdStrb_t;

  // One decimal digit step: returns {carry, digit}
  function automatic logic [DIGIT_W:0] decStep(input logic [DIGIT_W-1:0] a,
                                               input logic [DIGIT_W-1:0] b,
                                               input logic               cin);
    logic [DIGIT_W:0] s;
    logic [DIGIT_W:0] r;
    s = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
    if (s >= 5'd30)      r = s - 5'd30;
    else if (s >= 5'd20) r = s - 5'd20;
    else if (s >= 5'd10) r = s - 5'd10;
    else                 r = s;
    return {(s >= 5'd10), r[DIGIT_W-1:0]};
  endfunction
endpackage

// File: rtl/bcd_adder_ctrl.sv
module bcd_adder_ctrl
  import bcd_adder_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     byteMode,
  output bcdStrb_t strb,
  output logic     busy,
  output logic     done
);
  typedef enum logic {IDLE, RUN} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic             byteR;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx = byteR ? IDX_W'(BYTE_DIGITS - 1) : IDX_W'(NUM_DIGITS - 1);

  always_comb begin
    strb.load    = (state == IDLE) && start;
    strb.step    = (state == RUN);
    strb.finish  = (state == RUN) && (idx == lastIdx);
    strb.byteSel = byteR;
    strb.idx     = idx;
  end

  assign busy = (state == RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      idx   <= '0;
      byteR <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= strb.finish;
      case (state)
        IDLE: if (start) begin
          state <= RUN;
          idx   <= '0;
          byteR <= byteMode;
        end
        RUN: begin
          idx <= idx + 1'b1;
          if (idx == lastIdx) state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcd_adder_dp.sv
module bcd_adder_dp
  import bcd_adder_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bcdStrb_t          strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              vIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut,
  output logic              negOut,
  output logic              zeroOut,
  output logic              vOut
);
  logic [DATA_W-1:0]  aReg, bReg, accum, accNext, finalSum;
  logic               carryR, vR;
  logic [DIGIT_W-1:0] nibA, nibB;
  logic [DIGIT_W:0]   stepRes;

  always_comb begin
    nibA    = '0;
    nibB    = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (IDX_W'(i) == strb.idx) begin
        nibA = aReg[i*DIGIT_W +: DIGIT_W];
        nibB = bReg[i*DIGIT_W +: DIGIT_W];
      end
    end
    stepRes = decStep(nibA, nibB, carryR);
    accNext = accum;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (IDX_W'(i) == strb.idx) accNext[i*DIGIT_W +: DIGIT_W] = stepRes[DIGIT_W-1:0];
    end
    finalSum = strb.byteSel ? {{HALF_W{1'b0}}, accNext[HALF_W-1:0]} : accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg     <= '0;
      bReg     <= '0;
      accum    <= '0;
      carryR   <= 1'b0;
      vR       <= 1'b0;
      sumOut   <= '0;
      carryOut <= 1'b0;
      negOut   <= 1'b0;
      zeroOut  <= 1'b0;
      vOut     <= 1'b0;
    end else begin
      if (strb.load) begin
        aReg   <= opA;
        bReg   <= opB;
        accum  <= '0;
        carryR <= carryIn;
        vR     <= vIn;
      end else if (strb.step) begin
        accum  <= accNext;
        carryR <= stepRes[DIGIT_W];
      end
      if (strb.finish) begin
        sumOut   <= finalSum;
        carryOut <= stepRes[DIGIT_W];
        negOut   <= strb.byteSel ? finalSum[HALF_W-1] : finalSum[DATA_W-1];
        zeroOut  <= (finalSum == '0);
        vOut     <= vR;
      end
    end
  end
endmodule

// File: rtl/bcd_serial_adder.sv
module bcd_serial_adder
  import bcd_adder_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              vIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut,
  output logic              negOut,
  output logic              zeroOut,
  output logic              vOut
);
  bcdStrb_t strb;

  bcd_adder_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteMode(byteMode),
    .strb(strb), .busy(busy), .done(done)
  );

  bcd_adder_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .carryIn(carryIn), .vIn(vIn), .sumOut(sumOut), .carryOut(carryOut),
    .negOut(negOut), .zeroOut(zeroOut), .vOut(vOut)
  );
endmodule

// File: rtl/bcd_adder_chk.sv
module bcd_adder_chk
  import bcd_adder_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              byteMode,
  input logic              vIn,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] sumOut,
  input logic              carryOut,
  input logic              negOut,
  input logic              zeroOut,
  input logic              vOut
);
  logic       ckByte, ckV;
  logic [7:0] ckCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckByte <= 1'b0;
      ckV    <= 1'b0;
      ckCnt  <= '0;
    end else if (start && !busy) begin
      ckByte <= byteMode;
      ckV    <= vIn;
      ckCnt  <= '0;
    end else if (busy) begin
      ckCnt <= ckCnt + 1'b1;
    end
  end

  function automatic logic allDecimal(input logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (v[i*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ckCnt == (ckByte ? 8'(BYTE_DIGITS) : 8'(NUM_DIGITS))); // R3
  AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (!rstN) done |-> allDecimal(sumOut)); // R4
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (done && ckByte) |-> sumOut[DATA_W-1:HALF_W] == '0); // R6
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    done |-> negOut == (ckByte ? sumOut[HALF_W-1] : sumOut[DATA_W-1])); // R7
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    done |-> zeroOut == (sumOut == '0)); // R8
  AST_V_KEEP: assert property (@(posedge clk) disable iff (!rstN) done |-> vOut == ckV); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(sumOut) && $stable(carryOut) && $stable(negOut) && $stable(zeroOut)); // R12
endmodule

bind bcd_serial_adder bcd_adder_chk i_chk (.*);

// File: tb/test_bcd_serial_adder.sv
`timescale 1ns/1ps
module test_bcd_serial_adder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, byteMode = 1'b0, carryIn = 1'b0, vIn = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        busy, done, carryOut, negOut, zeroOut, vOut;
  logic [15:0] sumOut;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  bcd_serial_adder i_bcd_serial_adder (
    .clk(clk), .rstN(rstN), .start(start), .byteMode(byteMode), .opA(opA), .opB(opB),
    .carryIn(carryIn), .vIn(vIn), .busy(busy), .done(done), .sumOut(sumOut),
    .carryOut(carryOut), .negOut(negOut), .zeroOut(zeroOut), .vOut(vOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Decimal add by the digit rule, returns {carry, sum}
  function automatic logic [16:0] refAdd(input logic [15:0] a, input logic [15:0] b,
                                         input logic cin, input logic bm);
    int c = cin;
    int res = 0;
    int nd = bm ? 2 : 4;
    for (int i = 0; i < nd; i++) begin
      int s = ((a >> (4*i)) & 15) + ((b >> (4*i)) & 15) + c;
      c = (s >= 10) ? 1 : 0;
      res = res | ((s % 10) << (4*i));
    end
    return {c[0], res[15:0]};
  endfunction

  // Cycle-level reference model
  bit          mBusy, mDone, mC, mN, mZ, mV;
  int          mCnt;
  logic [15:0] mSum;
  logic [16:0] pend;
  bit          pendBm, pendV;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mCnt = 0; mSum = '0; mC = 0; mN = 0; mZ = 0; mV = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        mCnt--;
        if (mCnt == 0) begin
          mBusy = 0;
          mDone = 1;
          mSum  = pend[15:0];
          mC    = pend[16];
          mN    = pendBm ? pend[7] : pend[15];
          mZ    = (pend[15:0] == 16'h0);
          mV    = pendV;
        end
      end else if (start) begin
        pend   = refAdd(opA, opB, carryIn, byteMode);
        pendBm = byteMode;
        pendV  = vIn;
        mBusy  = 1;
        mCnt   = byteMode ? 2 : 4;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !ended) begin
      chk(busy == mBusy, "R2 R11 busy", busy, mBusy);
      chk(done == mDone, "R3 done", done, mDone);
      chk(sumOut == mSum, "R4 R6 R10 R12 sumOut", sumOut, mSum);
      chk(carryOut == mC, "R5 carryOut", carryOut, mC);
      chk(negOut == mN, "R7 negOut", negOut, mN);
      chk(zeroOut == mZ, "R8 zeroOut", zeroOut, mZ);
      chk(vOut == mV, "R9 vOut", vOut, mV);
    end
  end

  task automatic finishRun();
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    finishRun();
  end

  task automatic issue(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input logic bm, input logic v);
    @(negedge clk);
    opA = a; opB = b; carryIn = c; byteMode = bm; vIn = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opA = ~a; opB = ~b; carryIn = ~c; byteMode = ~bm; vIn = ~v;
  endtask

  task automatic waitDone();
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
  endtask

  task automatic runCase(input logic [15:0] a, input logic [15:0] b, input logic c,
                         input logic bm, input logic v, input logic [15:0] expS,
                         input logic expC, input string tag);
    issue(a, b, c, bm, v);
    waitDone();
    chk(done == 1'b1, {tag, " done seen"}, done, 1);
    chk(sumOut == expS, {tag, " sum"}, sumOut, expS);
    chk(carryOut == expC, {tag, " carry"}, carryOut, expC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && sumOut == 0 && carryOut == 0 && negOut == 0
        && zeroOut == 0 && vOut == 0, "R1 reset state", {busy, done, sumOut}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runCase(16'h1234, 16'h4321, 0, 0, 0, 16'h5555, 0, "R4 word plain");
    runCase(16'h0009, 16'h0001, 1, 0, 0, 16'h0011, 0, "R4 carry-in ripple");
    runCase(16'h9999, 16'h0001, 0, 0, 1, 16'h0000, 1, "R5 word wrap");
    chk(zeroOut == 1, "R8 zero after wrap", zeroOut, 1);
    chk(vOut == 1, "R9 v kept", vOut, 1);
    runCase(16'h5045, 16'h2340, 0, 1, 0, 16'h0085, 0, "R6 byte upper ignored");
    chk(negOut == 1, "R7 byte sign bit7", negOut, 1);
    runCase(16'h00FF, 16'h0001, 0, 1, 0, 16'h0066, 1, "R10 hex nibbles");
    runCase(16'h0099, 16'h0001, 0, 1, 0, 16'h0000, 1, "R5 byte carry out");

    // R11: second start while busy is ignored
    issue(16'h1234, 16'h4321, 0, 0, 0);
    @(negedge clk);
    opA = 16'h9999; opB = 16'h0001; byteMode = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    chk(sumOut == 16'h5555 && carryOut == 0, "R11 start while busy ignored", sumOut, 16'h5555);

    // R3: start during the done cycle is accepted
    issue(16'h0011, 16'h0022, 0, 1, 0);
    waitDone();
    start = 1'b1; opA = 16'h0044; opB = 16'h0055; byteMode = 1; carryIn = 0;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    chk(sumOut == 16'h0099, "R3 back-to-back start", sumOut, 16'h0099);

    for (int n = 0; n < 300; n++) begin
      issue(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      repeat (int'($urandom % 6)) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    finishRun();
  end
endmodule